// File: doc/BRIEF.md
# Chained Unsigned Magnitude Comparator

The block compares two unsigned words and reports on three output lines, exactly one of them high, whether the first operand is larger than, equal to, or smaller than the second. It is made of identical narrow comparator slices, 4 bits each by default. Each slice is built from single-bit relation cells. Each slice also has a three-line relation input from the slice below it. When a slice finds its own two operand fields identical, it forwards that incoming relation unchanged. Otherwise the slice's own result wins.

The top level stacks two slices for an 8-bit compare. The least-significant slice receives a fixed "equal" relation (greater 0, equal 1, less 0). Each slice passes its relation to the slice above it. The topmost slice's relation is captured in an output register, so a result appears one clock after its operands. Signed comparison is not supported.

Top module: `cmp_chain`

## Requirements
- R1: When operand `a_i` is larger than `b_i` as an unsigned number, `gt_o` is 1 one clock edge after the operands are sampled.
- R2: When `a_i` equals `b_i`, `eq_o` is 1 one clock edge after the operands are sampled.
- R3: When `a_i` is smaller than `b_i` as an unsigned number, `lt_o` is 1 one clock edge after the operands are sampled.
- R4: Outside reset, exactly one of `gt_o`, `eq_o` and `lt_o` is 1 in every cycle.
- R5: When the most-significant 4-bit fields of the operands differ, that field pair alone sets the result, whatever the lower fields hold.
- R6: When the most-significant fields are identical, the result is the relation of the next lower field pair. The 4-bit slice boundary falls between bit 3 and bit 4.
- R7: The outputs are registered. Operands sampled at clock edge n produce their result from edge n onward, and they do not affect the outputs before edge n.
- R8: While `rst` is sampled high, the outputs are set to greater 0, equal 1, less 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 8 | First unsigned operand |
| b_i | input | 8 | Second unsigned operand |
| gt_o | output | 1 | Registered: a_i greater than b_i |
| eq_o | output | 1 | Registered: a_i equal to b_i |
| lt_o | output | 1 | Registered: a_i less than b_i |

## Verification
The bound checker checks the following on every clock edge:
- the one-hot output invariant;
- the reset value;
- the one-cycle relation between operands and each of the three outputs;
- the priority of the upper field over the lower field, and the fall-through to the lower field when the upper fields tie.

Only the bench's scenarios can show that the whole 8-bit operand space is ordered correctly, and in particular the carry of "equal" through both slices when every bit matches. The bench drives every one of the 65536 operand pairs plus directed boundary pairs. It scores each result against an integer comparison.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  // Three-line relation carried between slices; exactly one field is set.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell (
  input  logic x_i,
  input  logic y_i,
  output logic gt_o,
  output logic eq_o,
  output logic lt_o
);
  assign gt_o = x_i & ~y_i;
  assign lt_o = ~x_i & y_i;
  assign eq_o = ~(x_i ^ y_i);
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  rel_t         casc_i,
  output rel_t         rel_o
);
  logic [W-1:0] c_gt, c_eq, c_lt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      cmp_bit_cell u_cell (
        .x_i (a_i[i]),
        .y_i (b_i[i]),
        .gt_o(c_gt[i]),
        .eq_o(c_eq[i]),
        .lt_o(c_lt[i])
      );
    end
  endgenerate

  // Scan from the top bit down; the first unequal bit decides.
  logic loc_gt, loc_lt, decided;
  always_comb begin
    loc_gt  = 1'b0;
    loc_lt  = 1'b0;
    decided = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!decided && !c_eq[i]) begin
        loc_gt  = c_gt[i];
        loc_lt  = c_lt[i];
        decided = 1'b1;
      end
    end
  end

  // A tied slice hands through the relation from below.
  assign rel_o.gt = loc_gt | (~decided & casc_i.gt);
  assign rel_o.lt = loc_lt | (~decided & casc_i.lt);
  assign rel_o.eq = ~decided & casc_i.eq;
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLICE_W*N_SLICES-1:0] a_i,
  input  logic [SLICE_W*N_SLICES-1:0] b_i,
  output logic                        gt_o,
  output logic                        eq_o,
  output logic                        lt_o
);
  localparam int TOTAL_W = SLICE_W * N_SLICES;

  rel_t link [N_SLICES+1];
  assign link[0] = REL_EQUAL;

  generate
    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
      cmp_slice #(.W(SLICE_W)) u_slice (
        .a_i   (a_i[s*SLICE_W +: SLICE_W]),
        .b_i   (b_i[s*SLICE_W +: SLICE_W]),
        .casc_i(link[s]),
        .rel_o (link[s+1])
      );
    end
  endgenerate

  rel_t res_q;
  always_ff @(posedge clk) begin
    if (rst) res_q <= REL_EQUAL;
    else     res_q <= link[N_SLICES];
  end

  assign gt_o = res_q.gt;
  assign eq_o = res_q.eq;
  assign lt_o = res_q.lt;

  logic unused_w;
  assign unused_w = (TOTAL_W == 0);
endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic [SLICE_W*N_SLICES-1:0] a_i,
  input logic [SLICE_W*N_SLICES-1:0] b_i,
  input logic                        gt_o,
  input logic                        eq_o,
  input logic                        lt_o
);
  localparam int TW = SLICE_W * N_SLICES;

  logic [SLICE_W-1:0] a_hi, b_hi, a_nx, b_nx;
  assign a_hi = a_i[TW-1 -: SLICE_W];
  assign b_hi = b_i[TW-1 -: SLICE_W];
  assign a_nx = a_i[TW-SLICE_W-1 -: SLICE_W];
  assign b_nx = b_i[TW-SLICE_W-1 -: SLICE_W];

  // R4
  onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({gt_o, eq_o, lt_o}) == 1);

  // R1
  gt_result_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i > b_i) |=> gt_o);

  // R2
  eq_result_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i == b_i) |=> eq_o);

  // R3
  lt_result_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i < b_i) |=> lt_o);

  // R8
  reset_value_chk: assert property (@(posedge clk)
    rst |=> (eq_o && !gt_o && !lt_o));

  // R5
  upper_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (a_hi < b_hi) |=> lt_o);

  // R6
  lower_falls_chk: assert property (@(posedge clk) disable iff (rst)
    (a_hi == b_hi && a_nx > b_nx) |=> gt_o);
endmodule

bind cmp_chain cmp_chain_chk #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) chk_i (
  .clk (clk),
  .rst (rst),
  .a_i (a_i),
  .b_i (b_i),
  .gt_o(gt_o),
  .eq_o(eq_o),
  .lt_o(lt_o)
);

// File: tb/cmp_chain_tb_top.sv
module cmp_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic gt, eq, lt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] exp;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_chain dut_i (
    .clk (clk),
    .rst (rst),
    .a_i (a),
    .b_i (b),
    .gt_o(gt),
    .eq_o(eq),
    .lt_o(lt)
  );

  // Driver: apply operands at a falling edge, queue the expected relation.
  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv);
    item_t it;
    @(negedge clk);
    a = av;
    b = bv;
    it.a = av;
    it.b = bv;
    it.exp = {(av > bv), (av == bv), (av < bv)};
    q.push_back(it);
  endtask

  function automatic string tag_of(input item_t it);
    string s;
    if (it.exp[2])      s = "R1";
    else if (it.exp[1]) s = "R2";
    else                s = "R3";
    if (it.a[7:4] != it.b[7:4]) s = {s, "/R5"};
    else                        s = {s, "/R6"};
    return {s, "/R7"};
  endfunction

  // Monitor: just after each rising edge the result of the last queued pair is visible.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({gt, eq, lt} !== it.exp) begin
          errors++;
          $display("FAIL %s a=%0d b=%0d actual gt/eq/lt=%b expected=%b",
                   tag_of(it), it.a, it.b, {gt, eq, lt}, it.exp);
        end
        checks++;
        if ($countones({gt, eq, lt}) != 1) begin
          errors++;
          $display("FAIL R4 a=%0d b=%0d actual gt/eq/lt=%b expected one-hot",
                   it.a, it.b, {gt, eq, lt});
        end
      end
    end
  end

  initial begin
    // R8: reset dominates operands that would give "greater".
    a = 8'hC3;
    b = 8'h12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({gt, eq, lt} !== 3'b010) begin
      errors++;
      $display("FAIL R8 actual gt/eq/lt=%b expected=010", {gt, eq, lt});
    end
    rst = 1'b0;

    // Directed corner cases.
    drive(8'h00, 8'h00);
    drive(8'hFF, 8'hFF);
    drive(8'h00, 8'hFF);
    drive(8'hFF, 8'h00);
    drive(8'h80, 8'h7F);
    drive(8'h10, 8'h0F);
    drive(8'h35, 8'h36);
    drive(8'h5A, 8'h5A);
    drive(8'h4F, 8'h50);

    // Exhaustive sweep of all operand pairs.
    for (int i = 0; i < 65536; i++) begin
      drive(i[15:8], i[7:0]);
    end
    repeat (3) @(negedge clk);

    // R7: a new pair does not reach the outputs before the next edge.
    drive(8'h01, 8'h02);
    @(posedge clk);
    #1;
    a = 8'h09;
    b = 8'h02;
    #2;
    checks++;
    if ({gt, eq, lt} !== 3'b001) begin
      errors++;
      $display("FAIL R7 actual gt/eq/lt=%b expected=001 before next edge", {gt, eq, lt});
    end
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule